// File: doc/BRIEF.md
# Odd-Parity Single-Correct Double-Detect Hamming Codec

This block protects a short message with a positional Hamming code that uses odd parity, plus one whole-word parity bit. The encoder half places the message bits and the check bits into a code word. The decoder half takes a received code word and does four things. It works out which check groups fail. It repairs a single flipped bit. It tells a repaired word apart from one that cannot be trusted. It returns the message. Both halves are purely combinational and share no state. A datapath can therefore put one on its write side and the other on its read side, with registers wherever its own timing needs them.

The message width is a parameter, 8 by default. The number of check bits follows from the width: it is the smallest k for which 2^k is at least the message width plus k plus 1. Code positions are counted from 1. Positions that are powers of two hold check bits. The remaining positions hold message bits, with the least significant message bit at the highest position.

Top module: `hamm_secded_codec`

## Requirements
- R1: Code word bit p-1 holds position p for p = 1..12, and bit 12 holds the overall parity bit. Check bits sit at positions 1, 2, 4 and 8. Message bits 7 down to 0 occupy positions 3, 5, 6, 7, 9, 10, 11, 12 in rising order, so position 12 carries bit 0. The message 8'h00 encodes to 13'h108B, and 8'hFF encodes to 13'h1FFC.
- R2: For each i, the positions whose index has bit i set hold an odd number of ones in every encoded word. This group includes the check bit at position 2^i.
- R3: All 13 bits of every encoded word together hold an odd number of ones.
- R4: Syndrome bit i is 1 exactly when group i holds an even number of ones in the received word. A single flipped positional bit therefore gives a syndrome equal to its position.
- R5: An undisturbed code word decodes to its message, with syndrome 0 and both flags low.
- R6: When the syndrome is in the range 1..12 and the overall count is even, the bit at that position is complemented. The original message is returned, single_fix_o is 1 and dbl_err_o is 0.
- R7: When only the overall parity bit is flipped, the syndrome is 0, single_fix_o is 1 and the message is returned unchanged.
- R8: When exactly two bits are flipped (two positional bits, or one positional bit and the overall bit), the overall count stays odd and the syndrome is nonzero. In that case dbl_err_o is 1, single_fix_o is 0, and msg_o holds the message bits as received, with nothing corrected.
- R9: Any syndrome above 12 raises dbl_err_o and suppresses correction. Examples: flips at positions 1, 4, 8 give syndrome 13, and flips at 1, 2, 12 give syndrome 15.
- R10: With a width of 4 there are three check bits and an 8-bit word with the overall bit at bit 7. The message 4'b0110 encodes to 8'h38. The same word with position 6 flipped decodes to syndrome 6, message 4'b0110 and single_fix_o = 1.
- R11: single_fix_o and dbl_err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| msg_i | input | MSG_W | Message to encode |
| cw_o | output | MSG_W+K+1 | Encoded word, overall parity bit in the top bit |
| cw_i | input | MSG_W+K+1 | Received word to decode |
| msg_o | output | MSG_W | Decoded, and where possible corrected, message |
| syndrome_o | output | K | Failing-group pattern, read as a bit position |
| single_fix_o | output | 1 | One bit was in error and has been dealt with |
| dbl_err_o | output | 1 | Word cannot be corrected (two errors or an impossible syndrome) |

## Verification
Every one of the 13 bits is flipped in turn on a fixed message. A design that counted positions from zero, or that ordered the message bits low-to-high, would return a message with the wrong bit changed and a syndrome off by one. A flip of the overall bit alone must leave the message untouched. A design that tried to correct "position 0" would corrupt a data bit or raise the double flag. Pairs of flips, including one that involves the overall bit, must raise only the double flag and return raw bits. Triple flips that yield syndromes 13 to 15 check that the decoder does not index past the word. The 4-bit case with position 6 flipped confirms that the width parameter moves the check positions and the odd-parity polarity correctly.

// File: rtl/hamm_pkg.sv
package hamm_pkg;

  // smallest k with 2^k >= m + k + 1
  function automatic int chk_bits(int m);
    int k;
    k = 1;
    while ((1 << k) < m + k + 1) k++;
    return k;
  endfunction

  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // 1-based position of message bit j; bit 0 lands on the highest data position
  function automatic int msg_pos(int m, int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < 4 * m + 8; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == m - 1 - j && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/hamm_enc.sv
module hamm_enc import hamm_pkg::*; #(
  parameter int MSG_W = 8,
  localparam int K = chk_bits(MSG_W),
  localparam int N = MSG_W + K
) (
  input  logic [MSG_W-1:0] msg_i,
  output logic [N:0]       cw_o
);

  logic [N-1:0] pos_w;
  logic         par;

  always_comb begin
    pos_w = '0;
    for (int j = 0; j < MSG_W; j++) pos_w[msg_pos(MSG_W, j) - 1] = msg_i[j];
    for (int i = 0; i < K; i++) begin
      par = 1'b1;  // odd parity: xnor of covered data bits
      for (int p = 1; p <= N; p++) begin
        if (p[i] && !is_pow2(p)) par = par ^ pos_w[p-1];
      end
      pos_w[(1 << i) - 1] = par;
    end
    cw_o = {~^pos_w, pos_w};
  end

endmodule

// File: rtl/hamm_syn.sv
module hamm_syn import hamm_pkg::*; #(
  parameter int MSG_W = 8,
  localparam int K = chk_bits(MSG_W),
  localparam int N = MSG_W + K
) (
  input  logic [N:0]   cw_i,
  output logic [K-1:0] syn_o,
  output logic         ovr_fail_o
);

  logic acc;

  always_comb begin
    syn_o = '0;
    for (int i = 0; i < K; i++) begin
      acc = 1'b0;
      for (int p = 1; p <= N; p++) begin
        if (p[i]) acc = acc ^ cw_i[p-1];
      end
      syn_o[i] = ~acc;  // even count fails odd parity
    end
    ovr_fail_o = ~^cw_i;
  end

endmodule

// File: rtl/hamm_fix.sv
module hamm_fix import hamm_pkg::*; #(
  parameter int MSG_W = 8,
  localparam int K = chk_bits(MSG_W),
  localparam int N = MSG_W + K
) (
  input  logic [N-1:0]     pos_i,
  input  logic [K-1:0]     syn_i,
  input  logic             ovr_fail_i,
  output logic [MSG_W-1:0] msg_o,
  output logic             single_o,
  output logic             dbl_o
);

  logic [N-1:0] fixed_w;
  int           idx;

  always_comb begin
    fixed_w  = pos_i;
    single_o = 1'b0;
    dbl_o    = 1'b0;
    idx      = int'(syn_i);
    if (idx == 0) begin
      single_o = ovr_fail_i;  // overall bit alone flipped
    end else if (!ovr_fail_i || idx > N) begin
      dbl_o = 1'b1;
    end else begin
      fixed_w[idx-1] = ~fixed_w[idx-1];
      single_o = 1'b1;
    end
    for (int j = 0; j < MSG_W; j++) msg_o[j] = fixed_w[msg_pos(MSG_W, j) - 1];
  end

endmodule

// File: rtl/hamm_secded_codec.sv
module hamm_secded_codec import hamm_pkg::*; #(
  parameter int MSG_W = 8,
  localparam int K = chk_bits(MSG_W),
  localparam int N = MSG_W + K,
  localparam int CW_W = N + 1
) (
  input  logic [MSG_W-1:0] msg_i,
  output logic [CW_W-1:0]  cw_o,
  input  logic [CW_W-1:0]  cw_i,
  output logic [MSG_W-1:0] msg_o,
  output logic [K-1:0]     syndrome_o,
  output logic             single_fix_o,
  output logic             dbl_err_o
);

  logic ovr_fail;

  hamm_enc #(.MSG_W(MSG_W)) i_enc (
    .msg_i (msg_i),
    .cw_o  (cw_o)
  );

  hamm_syn #(.MSG_W(MSG_W)) i_syn (
    .cw_i       (cw_i),
    .syn_o      (syndrome_o),
    .ovr_fail_o (ovr_fail)
  );

  hamm_fix #(.MSG_W(MSG_W)) i_fix (
    .pos_i      (cw_i[N-1:0]),
    .syn_i      (syndrome_o),
    .ovr_fail_i (ovr_fail),
    .msg_o      (msg_o),
    .single_o   (single_fix_o),
    .dbl_o      (dbl_err_o)
  );

endmodule

// File: rtl/hamm_codec_chk.sv
module hamm_codec_chk import hamm_pkg::*; #(
  parameter int MSG_W = 8,
  localparam int K = chk_bits(MSG_W),
  localparam int N = MSG_W + K,
  localparam int CW_W = N + 1
) (
  input logic [CW_W-1:0]  cw_o,
  input logic [CW_W-1:0]  cw_i,
  input logic [MSG_W-1:0] msg_o,
  input logic [K-1:0]     syndrome_o,
  input logic             single_fix_o,
  input logic             dbl_err_o
);

  logic [MSG_W-1:0] raw_w;
  logic             grp;

  always_comb begin
    for (int j = 0; j < MSG_W; j++) raw_w[j] = cw_i[msg_pos(MSG_W, j) - 1];

    assert_cw_odd_R3: assert (^cw_o == 1'b1) else $error("encoded word parity even");

    for (int i = 0; i < K; i++) begin
      grp = 1'b0;
      for (int p = 1; p <= N; p++) if (p[i]) grp = grp ^ cw_o[p-1];
      assert_group_odd_R2: assert (grp == 1'b1) else $error("check group %0d even", i);
    end

    assert_flags_excl_R11: assert (!(single_fix_o && dbl_err_o)) else $error("both flags high");

    assert_wide_syn_R9: assert (int'(syndrome_o) <= N || dbl_err_o) else $error("syndrome beyond word not flagged");

    assert_no_fix_dbl_R8: assert (!dbl_err_o || msg_o == raw_w) else $error("double error altered message");

    assert_zero_syn_R7: assert (syndrome_o != '0 || (msg_o == raw_w && !dbl_err_o)) else $error("zero syndrome changed message");

    assert_one_bit_fix_R6: assert (!single_fix_o || $countones(msg_o ^ raw_w) <= 1) else $error("correction touched several bits");
  end

endmodule

bind hamm_secded_codec hamm_codec_chk #(.MSG_W(MSG_W)) i_chk (
  .cw_o         (cw_o),
  .cw_i         (cw_i),
  .msg_o        (msg_o),
  .syndrome_o   (syndrome_o),
  .single_fix_o (single_fix_o),
  .dbl_err_o    (dbl_err_o)
);

// File: tb/test_hamm_secded_codec.sv
module test_hamm_secded_codec;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  msg_i = '0;
  logic [12:0] cw_o;
  logic [12:0] cw_i = '0;
  logic [7:0]  msg_o;
  logic [3:0]  syn_o;
  logic        sf_o, de_o;

  hamm_secded_codec i_hamm_secded_codec (
    .msg_i (msg_i), .cw_o (cw_o), .cw_i (cw_i), .msg_o (msg_o),
    .syndrome_o (syn_o), .single_fix_o (sf_o), .dbl_err_o (de_o)
  );

  logic [3:0] m4_i = '0;
  logic [7:0] c4_o;
  logic [7:0] c4_i = '0;
  logic [3:0] m4_o;
  logic [2:0] s4_o;
  logic       sf4_o, de4_o;

  hamm_secded_codec #(.MSG_W(4)) i_hamm_secded_codec_w4 (
    .msg_i (m4_i), .cw_o (c4_o), .cw_i (c4_i), .msg_o (m4_o),
    .syndrome_o (s4_o), .single_fix_o (sf4_o), .dbl_err_o (de4_o)
  );

  // scoreboard queues
  string       q_req[$];
  logic [12:0] q_cw[$];
  logic [7:0]  q_msg[$];
  logic [3:0]  q_syn[$];
  logic        q_sf[$];
  logic        q_de[$];

  // data positions of message bits 0..7 (R1)
  localparam int POS8 [8] = '{12, 11, 10, 9, 7, 6, 5, 3};

  function automatic logic [12:0] ref_enc(logic [7:0] m);
    logic [12:0] w;
    logic par;
    w = '0;
    for (int j = 0; j < 8; j++) w[POS8[j]-1] = m[j];
    for (int i = 0; i < 4; i++) begin
      par = 1'b1;
      for (int p = 1; p <= 12; p++)
        if (p[i] && ((p & (p - 1)) != 0)) par = par ^ w[p-1];
      w[(1 << i) - 1] = par;
    end
    w[12] = ~^w[11:0];
    return w;
  endfunction

  function automatic logic [7:0] raw_msg(logic [12:0] w);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = w[POS8[j]-1];
    return r;
  endfunction

  task automatic drive(string req, logic [7:0] m, logic [12:0] flips);
    logic [12:0] good, rx;
    int sy, nf;
    logic [7:0] em;
    logic esf, ede;
    good = ref_enc(m);
    rx   = good ^ flips;
    sy = 0;
    for (int p = 1; p <= 12; p++) if (flips[p-1]) sy = sy ^ p;
    nf = $countones(flips);
    em = m; esf = 1'b0; ede = 1'b0;
    if (nf == 0) begin
    end else if (nf % 2 == 1) begin
      if (sy <= 12) esf = 1'b1;
      else begin ede = 1'b1; em = raw_msg(rx); end
    end else begin
      ede = 1'b1; em = raw_msg(rx);
    end
    @(posedge clk);
    msg_i = m;
    cw_i  = rx;
    q_req.push_back(req);
    q_cw.push_back(good);
    q_msg.push_back(em);
    q_syn.push_back(sy[3:0]);
    q_sf.push_back(esf);
    q_de.push_back(ede);
  endtask

  always @(negedge clk) begin
    if (q_req.size() > 0) begin
      string r;
      logic [12:0] ecw;
      logic [7:0] em;
      logic [3:0] es;
      logic esf, ede;
      r = q_req.pop_front(); ecw = q_cw.pop_front(); em = q_msg.pop_front();
      es = q_syn.pop_front(); esf = q_sf.pop_front(); ede = q_de.pop_front();
      n_chk++;
      if (cw_o !== ecw || msg_o !== em || syn_o !== es || sf_o !== esf || de_o !== ede) begin
        n_fail++;
        $display("FAIL %s: actual cw=%h msg=%h syn=%0d sf=%b de=%b expected cw=%h msg=%h syn=%0d sf=%b de=%b",
                 r, cw_o, msg_o, syn_o, sf_o, de_o, ecw, em, es, esf, ede);
      end
      n_chk++;  // R11
      if (sf_o && de_o) begin
        n_fail++;
        $display("FAIL R11: actual sf=%b de=%b expected not both high", sf_o, de_o);
      end
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] msgs [7];
    msgs = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
    repeat (2) @(posedge clk);
    drive("R1 R5 idle word", 8'h00, 13'h0000);
    for (int k = 0; k < 7; k++) drive("R2 R3 R5 clean word", msgs[k], 13'h0000);
    for (int b = 0; b < 12; b++) drive("R4 R6 single positional flip", 8'hA5, 13'h0001 << b);
    for (int b = 0; b < 12; b += 3) drive("R4 R6 single flip alt", 8'h3C, 13'h0001 << b);
    drive("R7 overall bit flip", 8'hA5, 13'h1000);
    drive("R7 overall bit flip zero msg", 8'h00, 13'h1000);
    drive("R8 flips pos3 pos5", 8'hA5, 13'h0014);
    drive("R8 flips pos1 pos12", 8'h5A, 13'h0801);
    drive("R8 flip pos7 plus overall", 8'hFF, 13'h1040);
    drive("R8 flips pos9 pos10", 8'h3C, 13'h0300);
    drive("R9 syndrome 13", 8'hA5, 13'h0089);
    drive("R9 syndrome 14", 8'h5A, 13'h008A);
    drive("R9 syndrome 15", 8'hC3, 13'h0803);
    while (q_req.size() != 0) @(negedge clk);

    // R1 literal anchors
    @(posedge clk); msg_i = 8'h00;
    @(negedge clk); chk("R1 encode 00", {3'b0, cw_o}, 16'h108B);
    @(posedge clk); msg_i = 8'hFF;
    @(negedge clk); chk("R1 encode FF", {3'b0, cw_o}, 16'h1FFC);

    // R10 narrow instance
    @(posedge clk); m4_i = 4'b0110; c4_i = 8'h38;
    @(negedge clk);
    chk("R10 encode 0110", {8'h00, c4_o}, 16'h0038);
    chk("R10 clean syndrome", {13'h0, s4_o}, 16'h0000);
    @(posedge clk); c4_i = 8'h38 ^ 8'h20;
    @(negedge clk);
    chk("R10 syndrome for pos6", {13'h0, s4_o}, 16'h0006);
    chk("R10 recovered message", {12'h0, m4_o}, 16'h0006);
    chk("R10 single flag", {14'h0, sf4_o, de4_o}, 16'h0002);

    summary();
    $finish;
  end

endmodule